// File: doc/BRIEF.md
# Two-Wire Serial Slave Engine with Clock Stretching

This block is the slave side of a two-wire open-drain serial bus that is compatible with SMBus and I2C. It runs from the system clock and first passes both bus lines through a synchroniser and a glitch filter. It then detects START, repeated START and STOP conditions. After a START it shifts in an address byte and compares the upper seven bits with a programmable own address. When the general call option is enabled, it also accepts address zero for writes. On a match it acknowledges the address and then receives or transmits data bytes, depending on the read/write bit.

After every event that needs software, the engine holds SCL low and raises a service request. These events are a matched address, a received data byte, and a transmitted byte that the master acknowledged. SCL stays low until firmware pulses `svc_done`. At that point the engine takes the acknowledge choice or the next transmit byte. It places the next SDA value on the bus, waits a programmable setup time, and then releases SCL. During normal bit transfer, SDA changes only after a programmable hold time has passed since the engine saw SCL fall.

A global inhibit input returns the engine to idle and silences it, so it gives no acknowledge and drives no data. Both bus outputs are pull-low enables; a high level on the bus comes only from the external pull-ups. The bus rate is set by the master. Both standard mode (100 kbit/s) and fast mode (400 kbit/s) are within reach when the system clock is several megahertz or more.

States:
- `S_IDLE`: not addressed.
- `S_ADDR`: shifting in the address byte.
- `S_STRETCH`: SCL held low, waiting for firmware.
- `S_SETUP`: SDA is set, counting the setup time before SCL is released.
- `S_ACK_OUT`: driving the acknowledge bit.
- `S_HOLD`: counting the hold time before SDA changes.
- `S_RX`: receiving a data byte.
- `S_TX`: sending a data byte.
- `S_ACK_IN`: sampling the master's acknowledge.
- `S_DONE`: ignoring the bus until the next START or STOP.

Transitions:
- From any state: inhibit → `S_IDLE`, STOP → `S_IDLE`, START → `S_ADDR`.
- `S_ADDR` → `S_STRETCH` on a match, or → `S_DONE` on a miss.
- `S_STRETCH` → `S_SETUP` when firmware is done and the hold time has elapsed.
- `S_SETUP` → `S_ACK_OUT` or `S_TX`.
- `S_ACK_OUT` → `S_HOLD`.
- `S_HOLD` → `S_RX`, `S_TX`, `S_ACK_IN` or `S_DONE`.
- `S_RX` → `S_STRETCH` after 8 bits.
- `S_TX` → `S_HOLD` on each falling edge of SCL.
- `S_ACK_IN` → `S_STRETCH` on an ACK, or → `S_DONE` on a NACK.

Top module: `i2c_stretch_slave`

## Requirements
- R1: A START is SDA falling while SCL is high; it starts the address phase. A STOP is SDA rising while SCL is high; it returns the engine to idle with both pull-low outputs off and `svc_req` low.
- R2: The address byte is received MSB first. Its upper seven bits are the address and bit 0 is R/W (1 = read). A nonzero address equal to `own_addr` is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and neither line is pulled until the next START.
- R3: Address 0 with R/W = 0 is acknowledged only while `gc_en` is 1, and `gc_hit` then reads 1. Address 0 with R/W = 1 is never acknowledged.
- R4: After the eighth falling SCL edge of a matched address byte, the engine holds SCL low and raises `svc_req` until firmware pulses `svc_done`. It does the same after the eighth falling edge of a received data byte, and after the ninth falling edge of a transmitted byte that the master acknowledged. The `svc_kind` output reads 0 for an address with write, 1 for an address with read, 2 for a received byte, and 3 for a sent byte that was acknowledged.
- R5: A received data byte (MSB first) appears on `rx_data` while `svc_req` is high with kind 2. The ACK or NACK sent for that byte follows `ack_en` at the `svc_done` pulse, and after a NACK the engine drives nothing until the next START. The engine never pulls SDA while it is receiving bits.
- R6: In read mode, `tx_data` is taken at each `svc_done` of kind 1 or 3 and is sent MSB first; a 1 bit leaves SDA released. A NACK from the master ends the transfer, and SDA stays released until the next START.
- R7: A repeated START in the middle of a transfer returns the engine to the address phase, and a new address with either R/W value is then served.
- R8: While `inhibit` is 1, the engine gives no address acknowledge, raises no service request, and pulls neither line from the next clock on.
- R9: When a stretch ends, SDA takes its new value first. SCL is released at least `setup_cycles` and at most `setup_cycles`+3 clock cycles later.
- R10: When the engine itself lets SCL run, SDA changes no sooner than `hold_cycles`+1 clock cycles after SCL falls at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_pull_o | output | 1 | Pull SCL low (stretch) |
| sda_pull_o | output | 1 | Pull SDA low |
| own_addr | input | 7 | Own 7-bit slave address |
| gc_en | input | 1 | Accept general call address 0 |
| inhibit | input | 1 | Silence all slave responses |
| setup_cycles | input | TIME_W | SDA setup time before SCL release |
| hold_cycles | input | TIME_W | SDA hold time after SCL falls |
| ack_en | input | 1 | ACK (1) or NACK (0) for the received byte |
| tx_data | input | 8 | Next byte to transmit |
| svc_done | input | 1 | Firmware has serviced the request |
| svc_req | output | 1 | Service request; SCL is being stretched |
| svc_kind | output | 2 | Reason for the request (see R4) |
| gc_hit | output | 1 | The last matched address was the general call |
| rx_data | output | 8 | Last received data byte |

## Verification
The bench builds the block with SYNC_STAGES=2, FILT_LEN=3 and TIME_W=5. The hold and setup fields therefore reach 31 cycles, and the bench can exercise values of 10 and 12, which sit well above the filter latency. With that filter depth, a hold of 10 still changes SDA before the modelled master releases SCL. The gap measurements can then separate a correct hold or setup time from one that is ignored. Random transfers mix own-address, general-call and foreign addresses, both R/W values, random firmware ACK choices and transmit bytes, and inhibit. Directed runs cover repeated START, the general call enable, master NACK release, and the timing windows.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_HOLD, S_STRETCH, S_SETUP,
        S_ACK_OUT, S_RX, S_TX, S_ACK_IN, S_DONE
    } state_t;

    typedef enum logic [1:0] {
        K_ADDR_WR = 2'd0,
        K_ADDR_RD = 2'd1,
        K_RX      = 2'd2,
        K_TX      = 2'd3
    } kind_t;
endpackage

// File: rtl/i2cs_line_filter.sv
`timescale 1ns/1ps
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (sync_q[SYNC_STAGES-1] == line_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                run_q  <= '0;
                line_o <= sync_q[SYNC_STAGES-1];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cs_cond_detect.sv
`timescale 1ns/1ps
module i2cs_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    always_comb begin
        scl_rise = !scl_p && scl;
        scl_fall = scl_p && !scl;
        start_o  = scl_p && scl && sda_p && !sda;
        stop_o   = scl_p && scl && !sda_p && sda;
    end
endmodule

// File: rtl/i2cs_delay.sv
`timescale 1ns/1ps
module i2cs_delay #(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] value,
    output logic              done
);
    logic [TIME_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= value;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0) && !load;
endmodule

// File: rtl/i2c_stretch_slave.sv
`timescale 1ns/1ps
module i2c_stretch_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int TIME_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [6:0]        own_addr,
    input  logic              gc_en,
    input  logic              inhibit,
    input  logic [TIME_W-1:0] setup_cycles,
    input  logic [TIME_W-1:0] hold_cycles,
    input  logic              ack_en,
    input  logic [7:0]        tx_data,
    input  logic              svc_done,
    output logic              svc_req,
    output logic [1:0]        svc_kind,
    output logic              gc_hit,
    output logic [7:0]        rx_data
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g]));
    end

    logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2cs_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_o(start_c), .stop_o(stop_c));

    logic              ld_q, tmr_done;
    logic [TIME_W-1:0] ld_val_q;

    i2cs_delay #(.TIME_W(TIME_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(ld_q), .value(ld_val_q), .done(tmr_done));

    state_t            state, hold_tgt;
    kind_t             kind_q;
    logic [BYTE_W-1:0] sh_q, rx_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q, gc_q, ack_q, sda_q, sda_nx, fw_rdy, master_ack;
    logic              hit_own, hit_gc;

    assign hit_own = (sh_q[7:1] == own_addr) && (sh_q[7:1] != 7'd0);
    assign hit_gc  = gc_en && (sh_q[7:1] == 7'd0) && !sh_q[0];

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; hold_tgt <= S_IDLE; kind_q <= K_ADDR_WR;
            sh_q <= '0; rx_q <= '0; bit_cnt <= '0;
            rw_q <= 1'b0; gc_q <= 1'b0; ack_q <= 1'b0; sda_q <= 1'b0; sda_nx <= 1'b0;
            fw_rdy <= 1'b0; master_ack <= 1'b0; ld_q <= 1'b0; ld_val_q <= '0;
        end else begin
            ld_q <= 1'b0;
            if (inhibit || stop_c) begin
                state <= S_IDLE;
                sda_q <= 1'b0;
            end else if (start_c) begin
                state   <= S_ADDR;
                sda_q   <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    S_IDLE, S_DONE: ;
                    S_ADDR: begin
                        if (scl_rise) begin
                            sh_q    <= {sh_q[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            if (hit_own || hit_gc) begin
                                rw_q   <= sh_q[0];
                                gc_q   <= hit_gc;
                                kind_q <= sh_q[0] ? K_ADDR_RD : K_ADDR_WR;
                                state  <= S_STRETCH;
                                ld_q   <= 1'b1; ld_val_q <= hold_cycles; fw_rdy <= 1'b0;
                            end else begin
                                state <= S_DONE;
                            end
                        end
                    end
                    S_STRETCH: begin
                        if (svc_done) fw_rdy <= 1'b1;
                        if ((fw_rdy || svc_done) && tmr_done) begin
                            unique case (kind_q)
                                K_ADDR_WR: begin ack_q <= 1'b1; sda_q <= 1'b1; end
                                K_ADDR_RD: begin ack_q <= 1'b1; sda_q <= 1'b1; sh_q <= tx_data; end
                                K_RX:      begin ack_q <= ack_en; sda_q <= ack_en; end
                                K_TX:      begin sh_q <= tx_data; sda_q <= !tx_data[7]; bit_cnt <= '0; end
                            endcase
                            state <= S_SETUP;
                            ld_q  <= 1'b1; ld_val_q <= setup_cycles;
                        end
                    end
                    S_SETUP: if (tmr_done) state <= (kind_q == K_TX) ? S_TX : S_ACK_OUT;
                    S_ACK_OUT: begin
                        if (scl_fall) begin
                            ld_q <= 1'b1; ld_val_q <= hold_cycles; state <= S_HOLD;
                            bit_cnt <= '0;
                            if (!ack_q) begin
                                sda_nx <= 1'b0; hold_tgt <= S_DONE;
                            end else if (rw_q) begin
                                sda_nx <= !sh_q[7]; hold_tgt <= S_TX;
                            end else begin
                                sda_nx <= 1'b0; hold_tgt <= S_RX;
                            end
                        end
                    end
                    S_HOLD: if (tmr_done) begin sda_q <= sda_nx; state <= hold_tgt; end
                    S_RX: begin
                        if (scl_rise) begin
                            sh_q    <= {sh_q[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            rx_q   <= sh_q;
                            kind_q <= K_RX;
                            state  <= S_STRETCH;
                            ld_q   <= 1'b1; ld_val_q <= hold_cycles; fw_rdy <= 1'b0;
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            ld_q <= 1'b1; ld_val_q <= hold_cycles; state <= S_HOLD;
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                sda_nx <= 1'b0; hold_tgt <= S_ACK_IN;
                            end else begin
                                sh_q     <= {sh_q[6:0], 1'b0};
                                sda_nx   <= !sh_q[6];
                                bit_cnt  <= bit_cnt + 1'b1;
                                hold_tgt <= S_TX;
                            end
                        end
                    end
                    S_ACK_IN: begin
                        if (scl_rise) begin
                            master_ack <= !sda_f;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                kind_q <= K_TX;
                                state  <= S_STRETCH;
                                ld_q   <= 1'b1; ld_val_q <= hold_cycles; fw_rdy <= 1'b0;
                            end else begin
                                state <= S_DONE;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // output process
    always_comb begin
        scl_pull_o = (state == S_STRETCH) || (state == S_SETUP);
        sda_pull_o = sda_q;
        svc_req    = (state == S_STRETCH);
        svc_kind   = kind_q;
        gc_hit     = gc_q;
        rx_data    = rx_q;
    end

    assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (!scl_pull_o && !sda_pull_o && !svc_req));

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!scl_pull_o && !sda_pull_o && !svc_req));

    assert_rstart_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && !inhibit && !stop_c) |=> (state == S_ADDR));

    assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STRETCH && !svc_done && !fw_rdy && !inhibit && !start_c && !stop_c)
        |=> scl_pull_o);

    assert_rx_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RX) |-> !sda_pull_o);

    assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_IN && scl_fall && !scl_rise && !master_ack && !inhibit && !start_c && !stop_c)
        |=> (!sda_pull_o && state == S_DONE));
endmodule

// File: tb/i2c_stretch_slave_test.sv
`timescale 1ns/1ps
module i2c_stretch_slave_test;
    localparam int TW = 5;
    localparam int Q  = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mpull_scl = 1'b0, mpull_sda = 1'b0;
    logic scl_i, sda_i, scl_pull_o, sda_pull_o;
    logic [6:0] own_addr = 7'h2A;
    logic gc_en = 1'b0, inhibit = 1'b0, ack_en = 1'b0, svc_done = 1'b0;
    logic [TW-1:0] setup_cycles = '0, hold_cycles = '0;
    logic [7:0] tx_data = 8'h00, rx_data;
    logic svc_req, gc_hit;
    logic [1:0] svc_kind;

    always #2.5 clk = ~clk;

    assign scl_i = !(mpull_scl || scl_pull_o);
    assign sda_i = !(mpull_sda || sda_pull_o);

    i2c_stretch_slave #(.SYNC_STAGES(2), .FILT_LEN(3), .TIME_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .own_addr(own_addr),
        .gc_en(gc_en), .inhibit(inhibit), .setup_cycles(setup_cycles),
        .hold_cycles(hold_cycles), .ack_en(ack_en), .tx_data(tx_data),
        .svc_done(svc_done), .svc_req(svc_req), .svc_kind(svc_kind),
        .gc_hit(gc_hit), .rx_data(rx_data));

    int nchk = 0, nerr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // firmware model and event log
    int ev_n = 0, fw_ti = 0, fw_ai = 0, fw_delay = 10;
    int ev_kind[16], ev_rx[16], ev_gc[16];
    logic [7:0] fw_tx[8];
    bit fw_ack[8];

    initial begin
        forever begin
            @(negedge clk);
            if (svc_req) begin
                int k;
                k = int'(svc_kind);
                if (ev_n < 16) begin
                    ev_kind[ev_n] = k; ev_rx[ev_n] = int'(rx_data); ev_gc[ev_n] = int'(gc_hit);
                end
                ev_n++;
                tick(fw_delay);
                chk(scl_pull_o && !scl_i, "R4 SCL held low while waiting", int'(scl_pull_o), 1);
                if (k == 1 || k == 3) begin tx_data = fw_tx[fw_ti % 8]; fw_ti++; end
                if (k == 2) begin ack_en = fw_ack[fw_ai % 8]; fw_ai++; end
                svc_done = 1'b1;
                @(negedge clk);
                svc_done = 1'b0;
                while (svc_req) @(negedge clk);
            end
        end
    end

    // pin timing monitor
    int cyc = 0, t_fall = 0, t_sda = 0, min_hold = 1000, setup_gap = -1, pull_cnt = 0;
    logic scl_q = 1'b1, sdap_q = 1'b0, sclp_q = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (scl_q && !scl_i) t_fall = cyc;
        if (sda_pull_o != sdap_q) begin
            if (!scl_pull_o && (cyc - t_fall) < min_hold) min_hold = cyc - t_fall;
            t_sda = cyc;
        end
        if (sclp_q && !scl_pull_o) setup_gap = cyc - t_sda;
        if (scl_pull_o || sda_pull_o) pull_cnt++;
        scl_q = scl_i; sdap_q = sda_pull_o; sclp_q = scl_pull_o;
    end

    // master model
    task automatic wait_high();
        int n = 0;
        while (!scl_i && n < 3000) begin @(negedge clk); n++; end
    endtask
    task automatic m_start();
        mpull_sda = 1'b1; tick(Q); mpull_scl = 1'b1; tick(Q);
    endtask
    task automatic m_rstart();
        tick(Q); mpull_sda = 1'b0; tick(Q); mpull_scl = 1'b0; wait_high();
        tick(Q); mpull_sda = 1'b1; tick(Q); mpull_scl = 1'b1; tick(Q);
    endtask
    task automatic m_stop();
        tick(Q); mpull_sda = 1'b1; tick(Q); mpull_scl = 1'b0; wait_high();
        tick(Q); mpull_sda = 1'b0; tick(2 * Q);
    endtask
    task automatic m_wbit(input bit b);
        tick(Q); mpull_sda = !b; tick(Q); mpull_scl = 1'b0; wait_high();
        tick(2 * Q); mpull_scl = 1'b1;
    endtask
    task automatic m_rbit(output bit b);
        tick(Q); mpull_sda = 1'b0; tick(Q); mpull_scl = 1'b0; wait_high();
        tick(Q); b = sda_i; tick(Q); mpull_scl = 1'b1;
    endtask
    task automatic m_wbyte(input logic [7:0] d, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        acked = !b;
    endtask
    task automatic m_rbyte(output logic [7:0] d, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
        m_wbit(!give_ack);
    endtask

    function automatic bit exp_match(input logic [6:0] a, input bit rw, input bit inh);
        return !inh && (((a == own_addr) && (a != 7'd0)) || (gc_en && a == 7'd0 && !rw));
    endfunction

    task automatic xfer(input logic [6:0] a, input bit rw, input int nb, input bit inh);
        bit m, ack;
        logic [7:0] b;
        logic [7:0] wd[8];
        int expn;
        inhibit = inh;
        m = exp_match(a, rw, inh);
        for (int i = 0; i < nb; i++) begin
            fw_tx[i] = 8'($urandom); fw_ack[i] = ($urandom % 5) != 0; wd[i] = 8'($urandom);
        end
        ev_n = 0; fw_ti = 0; fw_ai = 0; pull_cnt = 0;
        m_start();
        m_wbyte({a, rw}, ack);
        chk(ack == m, inh ? "R8 inhibited address not acked" :
                      (a == 0 ? "R3 general call ack" : "R2 address ack"), int'(ack), int'(m));
        if (!m) begin
            chk(pull_cnt == 0 && ev_n == 0, inh ? "R8 no pull no request" : "R2 no pull on miss",
                pull_cnt + ev_n, 0);
        end else begin
            chk(ev_n == 1 && ev_kind[0] == int'(rw) && ev_gc[0] == int'(a == 0),
                "R4 address service kind", ev_kind[0], int'(rw));
            expn = 1;
            if (!rw) begin
                for (int i = 0; i < nb; i++) begin
                    m_wbyte(wd[i], ack);
                    expn++;
                    chk(ev_kind[expn-1] == 2 && ev_rx[expn-1] == int'(wd[i]),
                        "R5 received byte", ev_rx[expn-1], int'(wd[i]));
                    chk(ack == fw_ack[i], "R5 firmware ack choice", int'(ack), int'(fw_ack[i]));
                    if (!ack) break;
                end
            end else begin
                for (int i = 0; i < nb; i++) begin
                    m_rbyte(b, i != nb - 1);
                    chk(b == fw_tx[i], "R6 transmitted byte", int'(b), int'(fw_tx[i]));
                    if (i != nb - 1) expn++;
                end
                tick(30);
                chk(!sda_pull_o && !scl_pull_o, "R6 release after master nack",
                    int'(sda_pull_o), 0);
            end
            chk(ev_n == expn, "R4 service request count", ev_n, expn);
        end
        m_stop();
        tick(20);
        chk(!sda_pull_o && !scl_pull_o && !svc_req, "R1 idle after stop",
            int'(sda_pull_o) + int'(scl_pull_o) + int'(svc_req), 0);
        inhibit = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(5);
        chk(!scl_pull_o && !sda_pull_o && !svc_req, "R1 reset state released",
            int'(scl_pull_o) + int'(sda_pull_o), 0);
        rst_n = 1'b1;
        tick(10);

        // R9 / R10 timing windows
        setup_cycles = 5'd12; hold_cycles = 5'd10; min_hold = 1000; setup_gap = -1;
        fw_ack[0] = 1'b1;
        begin
            bit ack;
            ev_n = 0; fw_ti = 0; fw_ai = 0;
            m_start();
            m_wbyte({own_addr, 1'b0}, ack);
            chk(ack, "R2 own address acked", int'(ack), 1);
            chk(setup_gap >= 12 && setup_gap <= 15, "R9 setup before SCL release", setup_gap, 12);
            m_wbyte(8'hC3, ack);
            chk(min_hold >= 11 && min_hold <= 24, "R10 hold after SCL fall", min_hold, 11);
            chk(rx_data == 8'hC3, "R5 rx_data holds byte", int'(rx_data), 8'hC3);
            m_stop();
            tick(20);
        end

        // R7 repeated start: write then read
        setup_cycles = 5'd2; hold_cycles = 5'd1;
        begin
            bit ack;
            logic [7:0] b;
            ev_n = 0; fw_ti = 0; fw_ai = 0;
            fw_ack[0] = 1'b1; fw_tx[0] = 8'hA5;
            m_start();
            m_wbyte({own_addr, 1'b0}, ack);
            m_wbyte(8'h5C, ack);
            m_rstart();
            m_wbyte({own_addr, 1'b1}, ack);
            chk(ack, "R7 address after repeated start acked", int'(ack), 1);
            m_rbyte(b, 1'b0);
            chk(b == 8'hA5, "R7 read after repeated start", int'(b), 8'hA5);
            chk(ev_n == 3 && ev_kind[0] == 0 && ev_kind[1] == 2 && ev_kind[2] == 1,
                "R7 service sequence", ev_kind[2], 1);
            // R6: bytes clocked after a NACK read as all ones
            m_rbyte(b, 1'b0);
            chk(b == 8'hFF, "R6 no drive after nack", int'(b), 8'hFF);
            m_stop();
            tick(20);
        end

        // R3 general call enable
        gc_en = 1'b0; xfer(7'd0, 1'b0, 1, 1'b0);
        gc_en = 1'b1; xfer(7'd0, 1'b0, 2, 1'b0);
        xfer(7'd0, 1'b1, 1, 1'b0);
        // R8 inhibit
        xfer(own_addr, 1'b1, 1, 1'b1);

        // constrained random transfers
        for (int t = 0; t < 30; t++) begin
            logic [6:0] a;
            int sel;
            own_addr = 7'(1 + ($urandom % 127));
            gc_en = 1'($urandom);
            setup_cycles = TW'($urandom % 9);
            hold_cycles = TW'($urandom % 9);
            fw_delay = 1 + ($urandom % 30);
            sel = $urandom % 8;
            a = (sel < 4) ? own_addr : (sel < 6 ? 7'd0 : 7'($urandom));
            xfer(a, 1'($urandom), 1 + ($urandom % 3), ($urandom % 10) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule